// File: doc/BRIEF.md
# Endpoint Command Status Unit

This block keeps the per-endpoint status that a microprocessor manages through a byte-wide command port on a USB device controller. It serves sixteen endpoints. Index 0 is control OUT, index 1 is control IN, and indices 2 to 15 are data endpoints 1 to 14. For each endpoint it holds a stall flag, two full flags for a double buffer, the data PID that the next packet expects, and a select bit that names the buffer the CPU currently owns. Control OUT also carries a setup-present flag and a sticky overwrite flag.

The CPU writes a command code with a strobe. A status command latches an endpoint, and the next data-read strobe returns that endpoint's status byte one clock later. Clear-buffer commands release the CPU's buffer. The acknowledge command ends the lockout that an incoming setup packet places on the control endpoints. The serial-side engine drives single-cycle events: setup received, setup write finished, packet stored, buffer validated, and stall set or cleared. Each event carries an endpoint index.

Top module: `ep_cmd_status`

## Requirements
- R1: After reset every status bit of every endpoint is 0, and a read with no pending status command returns 00h.
- R2: Code D0h+n (n = 0..15) followed by a read strobe returns, in the clock after the strobe, the byte of endpoint n. The bits are 7 stall, 6 secondary full, 5 primary full, 4 next PID (0 = DATA0, 1 = DATA1), 3 setup overwrite, 2 setup present, 1 CPU select (0 = primary), and 0 reserved, which reads 0. Bits 3 and 2 read 0 for every endpoint other than 0.
- R3: A status read changes no status bit except the overwrite bit described in R9.
- R4: A read strobe with no pending status command returns 00h, and each status command serves only one read.
- R5: Code 70h (endpoint 0) or 72h..7Fh (endpoint n = code[3:0]) clears the full flag of the CPU-selected buffer and then inverts the select bit. Code 71h and any other code outside the defined set change nothing.
- R6: A setup-received event sets the setup-present bit of endpoint 0 and locks the control endpoints. While the lock holds, clear-buffer commands and validate events on endpoints 0 and 1 change nothing.
- R7: Code F4h releases the setup lock.
- R8: A setup-received event that arrives while the lock holds and endpoint 0 is not stalled sets the overwrite bit.
- R9: A status read of endpoint 0 clears the overwrite bit, but only when no setup write is in progress. A setup write starts with setup-received and ends with setup-done. The read still returns the bit's value from before the clear.
- R10: A packet-stored event toggles the endpoint's PID bit. It also sets the primary full flag if that flag is clear, otherwise the secondary full flag if that one is clear.
- R11: A validate event sets the full flag of the endpoint's CPU-selected buffer.
- R12: Stall-set and stall-clear events set and clear bit 7 of the addressed endpoint.
- R13: An accepted clear-buffer command on endpoint 0 also clears the setup-present bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_stb_i | input | 1 | Command code strobe |
| cmd_code_i | input | 8 | Command code |
| rd_stb_i | input | 1 | Data read strobe |
| rd_data_o | output | 8 | Status byte, valid the clock after a read strobe |
| ev_ep_i | input | 4 | Endpoint index for serial-side events |
| pkt_stored_i | input | 1 | Packet stored into the addressed endpoint |
| buf_valid_i | input | 1 | Buffer validated on the addressed endpoint |
| stall_set_i | input | 1 | Stall the addressed endpoint |
| stall_clr_i | input | 1 | Unstall the addressed endpoint |
| setup_rx_i | input | 1 | Setup packet arriving on control OUT |
| setup_done_i | input | 1 | Setup data write finished |

## Verification
On every cycle the assertions check four things: the PID toggle on each stored packet, that the buffer select holds still under a locked clear, that the acknowledge releases the lock, and that an idle read returns zero. They also check that overwrite only rises with a setup arrival and that it holds while a setup write is in progress. Other behaviour depends on a history of events, and only the bench scenarios show it. This covers the select-driven ping-pong of the full flags, the timing of the overwrite clear relative to setup-done, the suppression of overwrite while stalled, and the setup bit clearing on an accepted clear.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_STAT, CMD_CLR, CMD_ACK} cmd_e;
  localparam logic [3:0] STAT_HI = 4'hD;
  localparam logic [3:0] CLR_HI  = 4'h7;
  localparam logic [7:0] ACK_CODE = 8'hF4;
  typedef struct packed {
    logic stall;
    logic full1;
    logic full0;
    logic pid;
    logic ovw;
    logic setup;
    logic sel;
    logic rsvd;
  } ep_stat_t;
endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_cmd_pkg::*;
#(
  parameter int EP_W = 4
) (
  input  logic            stb_i,
  input  logic [7:0]      code_i,
  output cmd_e            cmd_o,
  output logic [EP_W-1:0] ep_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    ep_o  = code_i[EP_W-1:0];
    if (stb_i) begin
      if (code_i[7:4] == STAT_HI) cmd_o = CMD_STAT;
      // control IN has no clear code
      else if (code_i[7:4] == CLR_HI && code_i[3:0] != 4'd1) cmd_o = CMD_CLR;
      else if (code_i == ACK_CODE) cmd_o = CMD_ACK;
    end
  end
endmodule

// File: rtl/ep_setup_ctl.sv
module ep_setup_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_rx_i,
  input  logic setup_done_i,
  input  logic ack_i,
  input  logic rd0_i,
  input  logic clr0_i,
  input  logic stall0_i,
  output logic lock_o,
  output logic setup_o,
  output logic ovw_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      lock_o  <= 1'b0;
      setup_o <= 1'b0;
      ovw_o   <= 1'b0;
    end else begin
      if (setup_rx_i) wr_q <= 1'b1;
      else if (setup_done_i) wr_q <= 1'b0;
      if (setup_rx_i) lock_o <= 1'b1;
      else if (ack_i) lock_o <= 1'b0;
      if (setup_rx_i) setup_o <= 1'b1;
      else if (clr0_i) setup_o <= 1'b0;
      if (setup_rx_i && lock_o && !stall0_i) ovw_o <= 1'b1;
      else if (rd0_i && !wr_q) ovw_o <= 1'b0;
    end
  end

  p_ovw_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovw_o && !$past(ovw_o)) |-> $past(setup_rx_i));
  p_ovw_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovw_o) && $past(wr_q)) |-> ovw_o);
  p_ack_unlock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !setup_rx_i) |=> !lock_o);
endmodule

// File: rtl/ep_buf_bank.sv
module ep_buf_bank #(
  parameter int NUM_EP = 16,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EP_W-1:0]   ev_ep_i,
  input  logic              pkt_stored_i,
  input  logic              buf_valid_i,
  input  logic              stall_set_i,
  input  logic              stall_clr_i,
  input  logic              clr_i,
  input  logic [EP_W-1:0]   clr_ep_i,
  input  logic              lock_i,
  output logic [NUM_EP-1:0] stall_o,
  output logic [NUM_EP-1:0] full0_o,
  output logic [NUM_EP-1:0] full1_o,
  output logic [NUM_EP-1:0] pid_o,
  output logic [NUM_EP-1:0] sel_o,
  output logic              clr0_ok_o
);
  logic [NUM_EP-1:0] clr_go;

  assign clr0_ok_o = clr_go[0];

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    localparam bit IS_CTL = (g < 2);
    logic hit, blocked, val_go, st_go;
    logic [1:0] f_d;
    logic s_d;

    assign hit       = (ev_ep_i == EP_W'(g));
    assign blocked   = IS_CTL && lock_i;
    assign clr_go[g] = clr_i && (clr_ep_i == EP_W'(g)) && !blocked;
    assign val_go    = buf_valid_i && hit && !blocked;
    assign st_go     = pkt_stored_i && hit;

    always_comb begin
      f_d = {full1_o[g], full0_o[g]};
      s_d = sel_o[g];
      if (clr_go[g]) begin
        f_d[s_d] = 1'b0;
        s_d      = ~s_d;
      end
      if (st_go) begin
        if (!f_d[0]) f_d[0] = 1'b1;
        else if (!f_d[1]) f_d[1] = 1'b1;
      end
      if (val_go) f_d[s_d] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stall_o[g] <= 1'b0;
        full0_o[g] <= 1'b0;
        full1_o[g] <= 1'b0;
        pid_o[g]   <= 1'b0;
        sel_o[g]   <= 1'b0;
      end else begin
        if (stall_set_i && hit) stall_o[g] <= 1'b1;
        else if (stall_clr_i && hit) stall_o[g] <= 1'b0;
        full0_o[g] <= f_d[0];
        full1_o[g] <= f_d[1];
        sel_o[g]   <= s_d;
        if (st_go) pid_o[g] <= ~pid_o[g];
      end
    end

    p_pid_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pkt_stored_i && ev_ep_i == EP_W'(g)) |=> (pid_o[g] != $past(pid_o[g])));

    if (IS_CTL) begin : g_ctl
      p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && clr_ep_i == EP_W'(g) && lock_i) |=> $stable(sel_o[g]));
    end
  end
endmodule

// File: rtl/ep_cmd_status.sv
module ep_cmd_status
  import ep_cmd_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_stb_i,
  input  logic [7:0]      cmd_code_i,
  input  logic            rd_stb_i,
  output logic [7:0]      rd_data_o,
  input  logic [EP_W-1:0] ev_ep_i,
  input  logic            pkt_stored_i,
  input  logic            buf_valid_i,
  input  logic            stall_set_i,
  input  logic            stall_clr_i,
  input  logic            setup_rx_i,
  input  logic            setup_done_i
);
  cmd_e            cmd;
  logic [EP_W-1:0] cmd_ep;
  logic [NUM_EP-1:0] stall, full0, full1, pid, sel;
  logic lock, setup, ovw, clr0_ok;
  logic pend_q;
  logic [EP_W-1:0] pend_ep_q;
  ep_stat_t img;

  ep_cmd_decode #(.EP_W(EP_W)) i_dec (
    .stb_i(cmd_stb_i), .code_i(cmd_code_i), .cmd_o(cmd), .ep_o(cmd_ep)
  );

  ep_buf_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) i_bank (
    .clk_i, .rst_ni, .ev_ep_i, .pkt_stored_i, .buf_valid_i,
    .stall_set_i, .stall_clr_i,
    .clr_i(cmd == CMD_CLR), .clr_ep_i(cmd_ep), .lock_i(lock),
    .stall_o(stall), .full0_o(full0), .full1_o(full1), .pid_o(pid),
    .sel_o(sel), .clr0_ok_o(clr0_ok)
  );

  ep_setup_ctl i_setup (
    .clk_i, .rst_ni, .setup_rx_i, .setup_done_i,
    .ack_i(cmd == CMD_ACK),
    .rd0_i(rd_stb_i && pend_q && pend_ep_q == '0),
    .clr0_i(clr0_ok), .stall0_i(stall[0]),
    .lock_o(lock), .setup_o(setup), .ovw_o(ovw)
  );

  always_comb begin
    img       = '0;
    img.stall = stall[pend_ep_q];
    img.full1 = full1[pend_ep_q];
    img.full0 = full0[pend_ep_q];
    img.pid   = pid[pend_ep_q];
    img.sel   = sel[pend_ep_q];
    if (pend_ep_q == '0) begin
      img.ovw   = ovw;
      img.setup = setup;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_ep_q <= '0;
      rd_data_o <= '0;
    end else begin
      if (rd_stb_i) begin
        rd_data_o <= pend_q ? img : 8'h00;
        pend_q    <= 1'b0;
      end
      if (cmd == CMD_STAT) begin
        pend_q    <= 1'b1;
        pend_ep_q <= cmd_ep;
      end
    end
  end

  p_idle_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !pend_q) |=> (rd_data_o == 8'h00));
endmodule

// File: tb/test_ep_cmd_status.sv
module test_ep_cmd_status;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_stb_i = 0, rd_stb_i = 0;
  logic [7:0] cmd_code_i = 0;
  logic [7:0] rd_data_o;
  logic [3:0] ev_ep_i = 0;
  logic pkt_stored_i = 0, buf_valid_i = 0, stall_set_i = 0, stall_clr_i = 0;
  logic setup_rx_i = 0, setup_done_i = 0;

  ep_cmd_status i_ep_cmd_status (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bit m_stall[16], m_f0[16], m_f1[16], m_pid[16], m_sel[16];
  bit m_setup, m_ovw, m_wr, m_lock;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [7:0] exp_stat(int e);
    return {m_stall[e], m_f1[e], m_f0[e], m_pid[e],
            (e == 0) && m_ovw, (e == 0) && m_setup, m_sel[e], 1'b0};
  endfunction

  task automatic step;
    @(posedge clk_i); #1;
  endtask

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_code_i = c; cmd_stb_i = 1; step; cmd_stb_i = 0;
    if (c == 8'hF4) m_lock = 0;
    else if (c[7:4] == 4'h7 && c[3:0] != 4'd1) begin
      int e = int'(c[3:0]);
      if (!(e < 2 && m_lock)) begin
        if (m_sel[e]) m_f1[e] = 0; else m_f0[e] = 0;
        m_sel[e] = ~m_sel[e];
        if (e == 0) m_setup = 0;
      end
    end
  endtask

  task automatic rd_ep(int e, string r);
    logic [7:0] x;
    cmd(8'hD0 + 8'(e));
    x = exp_stat(e);
    rd_stb_i = 1; step; rd_stb_i = 0;
    check(r, rd_data_o, x);
    if (e == 0 && !m_wr) m_ovw = 0;
  endtask

  task automatic rd_idle(string r);
    rd_stb_i = 1; step; rd_stb_i = 0;
    check(r, rd_data_o, 8'h00);
  endtask

  // kind: 0 stored, 1 valid, 2 stall set, 3 stall clr, 4 setup rx, 5 setup done
  task automatic ev(int k, int e);
    ev_ep_i = 4'(e);
    case (k)
      0: pkt_stored_i = 1;
      1: buf_valid_i  = 1;
      2: stall_set_i  = 1;
      3: stall_clr_i  = 1;
      4: setup_rx_i   = 1;
      default: setup_done_i = 1;
    endcase
    step;
    {pkt_stored_i, buf_valid_i, stall_set_i, stall_clr_i, setup_rx_i, setup_done_i} = '0;
    case (k)
      0: begin
        m_pid[e] = ~m_pid[e];
        if (!m_f0[e]) m_f0[e] = 1; else if (!m_f1[e]) m_f1[e] = 1;
      end
      1: if (!(e < 2 && m_lock)) begin
        if (m_sel[e]) m_f1[e] = 1; else m_f0[e] = 1;
      end
      2: m_stall[e] = 1;
      3: m_stall[e] = 0;
      4: begin
        if (m_lock && !m_stall[0]) m_ovw = 1;
        m_setup = 1; m_lock = 1; m_wr = 1;
      end
      default: m_wr = 0;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step;
    rst_ni = 1; step;
    // R1 reset state
    for (int e = 0; e < 16; e++) rd_ep(e, "R1 reset");
    rd_idle("R1 idle after reset");
    rd_idle("R4 no pending command");
    // R10 / R5 / R11 ping-pong on endpoint index 3
    ev(0, 3); rd_ep(3, "R10 first store");
    ev(0, 3); rd_ep(3, "R10 second store");
    ev(0, 3); rd_ep(3, "R10 store when both full");
    cmd(8'h73); rd_ep(3, "R5 clear primary");
    rd_ep(3, "R3 reread unchanged");
    cmd(8'h73); rd_ep(3, "R5 clear secondary");
    ev(1, 3); rd_ep(3, "R11 validate selected");
    cmd(8'h71); rd_ep(1, "R5 code 71h ignored");
    cmd(8'h00); rd_ep(3, "R5 undefined code ignored");
    // R12
    ev(2, 5); rd_ep(5, "R12 stall set");
    ev(3, 5); rd_ep(5, "R12 stall clear");
    // R6 lockout
    ev(0, 0); ev(1, 1);
    ev(4, 0); rd_ep(0, "R6 setup present");
    cmd(8'h70); rd_ep(0, "R6 clear locked ep0");
    ev(1, 1); cmd(8'hD1);
    rd_stb_i = 1; step; rd_stb_i = 0; check("R6 validate locked ep1", rd_data_o, exp_stat(1));
    // R8 / R9
    ev(4, 0); rd_ep(0, "R8 overwrite set");
    rd_ep(0, "R9 held while writing");
    ev(5, 0); rd_ep(0, "R9 read after done");
    rd_ep(0, "R9 cleared by read");
    // R7 / R13
    cmd(8'hF4); cmd(8'h70); rd_ep(0, "R13 setup cleared by clear");
    rd_ep(0, "R7 clear accepted after ack");
    // R8 no overwrite while stalled
    ev(4, 0); ev(2, 0); ev(4, 0); ev(5, 0);
    rd_ep(0, "R8 stalled no overwrite");
    ev(3, 0); cmd(8'hF4);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 11);
      int e  = $urandom_range(0, 15);
      case (op)
        0, 1: ev(0, e);
        2: ev(1, e);
        3: ev($urandom_range(2, 3), e);
        4: ev(4, 0);
        5: ev(5, 0);
        6: cmd(8'hF4);
        7, 8: cmd(8'h70 + 8'($urandom_range(0, 15)));
        9: rd_idle("R4 random idle");
        default: rd_ep(e, "R2 random status");
      endcase
    end
    for (int e = 0; e < 16; e++) rd_ep(e, "R2 final sweep");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule